// File: doc/BRIEF.md
# Sector Write Sequencer for a Protected Parallel Flash

This block runs on the host side of a byte-wide parallel flash that only accepts writes one whole sector at a time and only after a fixed command prefix. A single start pulse selects a sector number and a completion-detect method. The sequencer then issues the three-write command prefix and takes 64 payload bytes from a valid/ready stream. It places each byte at its offset inside the chosen sector with its own write-enable strobe, and polls the device until the internal write is complete.

Payload back-pressure works as follows. `in_ready_o` is high only while the sequencer is waiting for the next byte, and never during a strobe. A byte transfers on a clock edge where `in_valid_i` and `in_ready_o` are both high. The producer may hold `in_valid_i` low for any number of cycles, but the device abandons a load once the pause gets too long. For that reason the sequencer counts idle cycles while it waits. When the count reaches the guard limit it gives up, raises an underrun pulse and returns to idle.

Completion detection has two modes. In the first, the last loaded address is read again until bit 7 matches bit 7 of the last byte written. In the second, reads repeat until bit 6 gives the same value on two reads in a row. If polling runs past the program-time budget, a timeout pulse replaces the done pulse.

Top module: `sector_prog_ctrl`

## Requirements
- R1: After reset, the three bus strobes (`bus_ce_n_o`, `bus_we_n_o`, `bus_oe_n_o`) are high, the data bus is not driven, and `in_ready_o`, `busy_o`, `done_o`, `timeout_o` and `underrun_o` are low.
- R2: Every accepted start request begins with three write cycles carrying the parameter pairs (UNLK_A0, UNLK_D0), (UNLK_A1, UNLK_D1), (UNLK_A2, UNLK_D2), in that order, before any payload byte is written.
- R3: Every write cycle does the following: it drives address and data with chip enable low and output enable high for SETUP_CYC cycles, then holds write enable low for exactly WE_LOW_CYC cycles, then releases write enable while address and data are still held. Address and data do not change while write enable is low.
- R4: The k-th payload byte (k = 0..63) is written to bus address {sector, k}. The sector number occupies address bits 14..6 and the offset occupies bits 5..0. The byte's value is exactly as received.
- R5: `in_ready_o` is high only while the sequencer waits for a payload byte. Each request accepts exactly 64 bytes and issues exactly 64 payload writes, never fewer.
- R6: If the sequencer waits GAP_GUARD_CYC cycles for a payload byte without receiving one, it pulses `underrun_o` for one cycle and returns to idle, and it issues no further bus cycles.
- R7: With `toggle_mode_i` = 0 at start, `done_o` pulses only after a read of the last loaded address returns bit 7 equal to bit 7 of the last byte written.
- R8: With `toggle_mode_i` = 1 at start, `done_o` pulses only after two consecutive reads of the last loaded address return the same bit 6.
- R9: If a poll read completes without a match after at least PROG_TMO_CYC cycles of polling, the sequencer pulses `timeout_o` instead of `done_o` and returns to idle.
- R10: At most one of `done_o`, `timeout_o` and `underrun_o` is high in any cycle, each for one cycle, and `busy_o` is low in the following cycle. A start pulse while `busy_o` is high is ignored.
- R11: A read cycle holds output enable low for exactly ACC_CYC cycles, with write enable high and the data bus released, and never overlaps a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sector write (ignored while busy) |
| sector_i | input | 9 | Sector number, sampled with start_i |
| toggle_mode_i | input | 1 | 0: bit-7 data poll, 1: bit-6 toggle poll; sampled with start_i |
| in_valid_i | input | 1 | Payload byte valid |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Sequencer can take a payload byte |
| busy_o | output | 1 | A sector write is in progress |
| done_o | output | 1 | One-cycle pulse: write completed |
| timeout_o | output | 1 | One-cycle pulse: polling exceeded the program budget |
| underrun_o | output | 1 | One-cycle pulse: payload stalled past the gap guard |
| bus_addr_o | output | 15 | Flash address bus |
| bus_dout_o | output | 8 | Data towards the flash |
| bus_drv_o | output | 1 | High while the host drives the data bus |
| bus_din_i | input | 8 | Data from the flash |
| bus_ce_n_o | output | 1 | Chip enable, active low |
| bus_we_n_o | output | 1 | Write enable, active low |
| bus_oe_n_o | output | 1 | Output enable, active low |

## Verification
The hardest case to reach is a completion decision made against a device that is still busy. This covers a poll read that sees the inverted bit 7 or a flipping bit 6, and a timeout that must fire while the device has not finished. The bench pairs the sequencer with a behavioural flash that follows the command prefix, the sector load and the gap rule. Each table entry sets that model's internal write time, so some runs finish within the poll budget and others outlast it in both detect modes. Producer stalls just under the guard and a stream cut off after ten bytes push the gap guard to both sides of its limit.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    CT_IDLE,
    CT_UNLK,
    CT_WAIT,
    CT_LOAD,
    CT_POLL
  } ctl_st_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACT,
    PH_REC
  } bus_ph_t;
endpackage

// File: rtl/sp_wait_timer.sv
module sp_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt <= '0;
    end else if (cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired_o = (cnt == CW'(LIMIT));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/sp_bus_cycle.sv
module sp_bus_cycle
  import sp_pkg::*;
#(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int WE_LOW_CYC = 4,
  parameter int ACC_CYC    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_drv_o,
  input  logic [DW-1:0] bus_din_i,
  output logic          bus_ce_n_o,
  output logic          bus_we_n_o,
  output logic          bus_oe_n_o
);
  localparam int M1   = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int MAXC = (M1 > ACC_CYC) ? M1 : ACC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bus_ph_t       ph;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_o <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (req_i) begin
          ph     <= PH_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
          rd_q   <= rd_i;
          addr_q <= addr_i;
          data_q <= wdata_i;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_ACT;
          cnt <= rd_q ? CW'(ACC_CYC - 1) : CW'(WE_LOW_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_ACT: if (cnt == '0) begin
          ph <= PH_REC;
          if (rd_q) rdata_o <= bus_din_i;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy_o     = (ph != PH_IDLE);
  assign ack_o      = (ph == PH_REC);
  assign bus_addr_o = addr_q;
  assign bus_dout_o = data_q;
  assign bus_drv_o  = (ph != PH_IDLE) && !rd_q;
  assign bus_ce_n_o = (ph == PH_IDLE);
  assign bus_we_n_o = !((ph == PH_ACT) && !rd_q);
  assign bus_oe_n_o = !((ph == PH_ACT) && rd_q);

  logic [CW:0] wl_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || bus_we_n_o) wl_cnt <= '0;
    else                      wl_cnt <= wl_cnt + 1'b1;
  end

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n_o) |-> (wl_cnt == (CW+1)'(WE_LOW_CYC)));

  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n_o && !$past(bus_we_n_o)) |-> ($stable(bus_addr_o) && $stable(bus_dout_o)));

  // R3
  we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n_o |-> (!bus_ce_n_o && bus_oe_n_o && bus_drv_o));

  // R11
  oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n_o |-> (bus_we_n_o && !bus_drv_o && !bus_ce_n_o));
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import sp_pkg::*;
#(
  parameter int          AW            = 15,
  parameter int          DW            = 8,
  parameter int          SECTOR_BYTES  = 64,
  parameter int          SETUP_CYC     = 2,
  parameter int          WE_LOW_CYC    = 4,
  parameter int          ACC_CYC       = 32,
  parameter int          GAP_GUARD_CYC = 29000,
  parameter int          PROG_TMO_CYC  = 4000000,
  parameter logic [14:0] UNLK_A0       = 15'h5555,
  parameter logic [7:0]  UNLK_D0       = 8'hAA,
  parameter logic [14:0] UNLK_A1       = 15'h2AAA,
  parameter logic [7:0]  UNLK_D1       = 8'h55,
  parameter logic [14:0] UNLK_A2       = 15'h5555,
  parameter logic [7:0]  UNLK_D2       = 8'hA0,
  localparam int         OFF_W         = $clog2(SECTOR_BYTES),
  localparam int         SEC_W         = AW - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic             toggle_mode_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             in_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             underrun_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_dout_o,
  output logic             bus_drv_o,
  input  logic [DW-1:0]    bus_din_i,
  output logic             bus_ce_n_o,
  output logic             bus_we_n_o,
  output logic             bus_oe_n_o
);
  ctl_st_t          st;
  logic [1:0]       ul_idx;
  logic [OFF_W-1:0] byte_cnt;
  logic [SEC_W-1:0] sec_q;
  logic             mode_q, inflight, first_q, prev6_q;
  logic [DW-1:0]    data_q, last_q;

  logic             eng_req, eng_rd, eng_busy, eng_ack;
  logic [AW-1:0]    eng_addr;
  logic [DW-1:0]    eng_wdata, eng_rdata;
  logic             gap_exp, prog_exp;

  assign eng_req = ((st == CT_UNLK) || (st == CT_LOAD) || (st == CT_POLL)) && !inflight;
  assign eng_rd  = (st == CT_POLL);

  always_comb begin
    eng_addr  = {sec_q, byte_cnt};
    eng_wdata = data_q;
    if (st == CT_UNLK) begin
      case (ul_idx)
        2'd0:    begin eng_addr = AW'(UNLK_A0); eng_wdata = DW'(UNLK_D0); end
        2'd1:    begin eng_addr = AW'(UNLK_A1); eng_wdata = DW'(UNLK_D1); end
        default: begin eng_addr = AW'(UNLK_A2); eng_wdata = DW'(UNLK_D2); end
      endcase
    end
  end

  sp_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC), .ACC_CYC(ACC_CYC)
  ) cyc_i (
    .clk(clk), .rst_n(rst_n), .req_i(eng_req), .rd_i(eng_rd), .addr_i(eng_addr),
    .wdata_i(eng_wdata), .busy_o(eng_busy), .ack_o(eng_ack), .rdata_o(eng_rdata),
    .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o), .bus_drv_o(bus_drv_o),
    .bus_din_i(bus_din_i), .bus_ce_n_o(bus_ce_n_o), .bus_we_n_o(bus_we_n_o),
    .bus_oe_n_o(bus_oe_n_o)
  );

  sp_wait_timer #(.LIMIT(GAP_GUARD_CYC)) gap_i (
    .clk(clk), .rst_n(rst_n), .run_i(st == CT_WAIT), .expired_o(gap_exp)
  );

  sp_wait_timer #(.LIMIT(PROG_TMO_CYC)) prog_i (
    .clk(clk), .rst_n(rst_n), .run_i(st == CT_POLL), .expired_o(prog_exp)
  );

  logic poll_hit;
  assign poll_hit = mode_q ? (!first_q && (eng_rdata[6] == prev6_q))
                           : (eng_rdata[7] == last_q[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= CT_IDLE;
      ul_idx     <= '0;
      byte_cnt   <= '0;
      sec_q      <= '0;
      mode_q     <= 1'b0;
      inflight   <= 1'b0;
      first_q    <= 1'b0;
      prev6_q    <= 1'b0;
      data_q     <= '0;
      last_q     <= '0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      underrun_o <= 1'b0;
      if (eng_req) inflight <= 1'b1;
      if (eng_ack) inflight <= 1'b0;
      case (st)
        CT_IDLE: if (start_i) begin
          sec_q    <= sector_i;
          mode_q   <= toggle_mode_i;
          ul_idx   <= '0;
          byte_cnt <= '0;
          st       <= CT_UNLK;
        end
        CT_UNLK: if (eng_ack) begin
          if (ul_idx == 2'd2) st <= CT_WAIT;
          else                ul_idx <= ul_idx + 1'b1;
        end
        CT_WAIT: if (in_valid_i) begin
          data_q <= in_data_i;
          st     <= CT_LOAD;
        end else if (gap_exp) begin
          underrun_o <= 1'b1;
          st         <= CT_IDLE;
        end
        CT_LOAD: if (eng_ack) begin
          last_q <= data_q;
          if (byte_cnt == '1) begin
            first_q <= 1'b1;
            st      <= CT_POLL;
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
            st       <= CT_WAIT;
          end
        end
        CT_POLL: if (eng_ack) begin
          first_q <= 1'b0;
          prev6_q <= eng_rdata[6];
          if (poll_hit) begin
            done_o <= 1'b1;
            st     <= CT_IDLE;
          end else if (prog_exp) begin
            timeout_o <= 1'b1;
            st        <= CT_IDLE;
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

  assign in_ready_o = (st == CT_WAIT);
  assign busy_o     = (st != CT_IDLE);

  // R10
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, underrun_o}));

  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o || underrun_o) |-> !busy_o);

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (bus_ce_n_o && !eng_busy));

  // R6
  underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> (bus_ce_n_o && !busy_o));

  // R2
  req_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> !eng_busy);
endmodule

// File: tb/sector_prog_ctrl_tb.sv
`timescale 1ns/1ps
module sector_prog_ctrl_tb_top;
  localparam int SETUP = 2;
  localparam int WLOW  = 3;
  localparam int ACC   = 30;
  localparam int GAP   = 400;
  localparam int PTMO  = 5000;
  localparam logic [14:0] UA0 = 15'h5555, UA1 = 15'h2AAA, UA2 = 15'h5555;
  localparam logic [7:0]  UD0 = 8'hAA,    UD1 = 8'h55,    UD2 = 8'hA0;

  localparam int NV = 6;
  // sector, mode, model busy cycles, seed, stall before byte 20, expected (0 done, 1 timeout)
  localparam int V_SEC  [NV] = '{'h000, 'h1FF, 'h0A5, 'h123, 'h05A, 'h100};
  localparam int V_MODE [NV] = '{0, 1, 0, 0, 1, 1};
  localparam int V_BUSY [NV] = '{300, 900, 1, 8000, 8000, 50};
  localparam int V_SEED [NV] = '{'h10, 'h80, 'hF0, 'h33, 'h7F, 'hC3};
  localparam int V_STAL [NV] = '{0, 0, 100, 0, 0, 350};
  localparam int V_EXP  [NV] = '{0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start_i, toggle_mode_i, in_valid_i;
  logic [8:0]  sector_i;
  logic [7:0]  in_data_i, bus_din_i, bus_dout_o;
  logic        in_ready_o, busy_o, done_o, timeout_o, underrun_o;
  logic [14:0] bus_addr_o;
  logic        bus_drv_o, bus_ce_n_o, bus_we_n_o, bus_oe_n_o;

  sector_prog_ctrl #(
    .SETUP_CYC(SETUP), .WE_LOW_CYC(WLOW), .ACC_CYC(ACC), .GAP_GUARD_CYC(GAP),
    .PROG_TMO_CYC(PTMO), .UNLK_A0(UA0), .UNLK_D0(UD0), .UNLK_A1(UA1),
    .UNLK_D1(UD1), .UNLK_A2(UA2), .UNLK_D2(UD2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
    .toggle_mode_i(toggle_mode_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .underrun_o(underrun_o), .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o),
    .bus_drv_o(bus_drv_o), .bus_din_i(bus_din_i), .bus_ce_n_o(bus_ce_n_o),
    .bus_we_n_o(bus_we_n_o), .bus_oe_n_o(bus_oe_n_o)
  );

  // Behavioural flash: 0..2 prefix stages, 3 loading, 4 internal write
  int         mst, nload, ld_err, ul_bad, gapc, mbusy, nwr, busy_len;
  int         wl, wl_min, wl_max, ol, ol_min, ol_max;
  logic [7:0] mbuf [64];
  logic [8:0] msec;
  logic [5:0] last_off;
  logic       tog, we_q, oe_q, clr_stats;

  always @(posedge clk) begin
    we_q <= bus_we_n_o;
    oe_q <= bus_oe_n_o;
    if (!rst_n) begin
      mst <= 0; nload <= 0; gapc <= 0; mbusy <= 0; tog <= 1'b0; msec <= '0; last_off <= '0;
      ld_err <= 0; ul_bad <= 0; nwr <= 0; wl <= 0; ol <= 0;
      wl_min <= 1000; wl_max <= 0; ol_min <= 1000; ol_max <= 0;
      for (int k = 0; k < 64; k++) mbuf[k] <= 8'hFF;
    end else begin
      if (clr_stats) begin
        ld_err <= 0; ul_bad <= 0; nwr <= 0;
        wl_min <= 1000; wl_max <= 0; ol_min <= 1000; ol_max <= 0;
      end
      if (!bus_we_n_o) wl <= wl + 1;
      else if (!we_q) begin
        if (wl < wl_min) wl_min <= wl;
        if (wl > wl_max) wl_max <= wl;
        wl <= 0;
      end
      if (!bus_oe_n_o) ol <= ol + 1;
      else if (!oe_q) begin
        if (ol < ol_min) ol_min <= ol;
        if (ol > ol_max) ol_max <= ol;
        ol <= 0;
      end
      if (oe_q && !bus_oe_n_o && mst == 4) tog <= ~tog;
      if (!we_q && bus_we_n_o && !bus_ce_n_o) begin
        nwr <= nwr + 1;
        case (mst)
          0: if (bus_addr_o == UA0 && bus_dout_o == UD0) mst <= 1; else ul_bad <= ul_bad + 1;
          1: if (bus_addr_o == UA1 && bus_dout_o == UD1) mst <= 2; else begin mst <= 0; ul_bad <= ul_bad + 1; end
          2: if (bus_addr_o == UA2 && bus_dout_o == UD2) begin
               mst <= 3; nload <= 0; gapc <= 0;
               for (int k = 0; k < 64; k++) mbuf[k] <= 8'hFF;
             end else begin mst <= 0; ul_bad <= ul_bad + 1; end
          3: begin
               if (nload == 0) msec <= bus_addr_o[14:6];
               else if (bus_addr_o[14:6] != msec) ld_err <= ld_err + 1;
               if (bus_addr_o[5:0] != 6'(nload)) ld_err <= ld_err + 1;
               mbuf[bus_addr_o[5:0]] <= bus_dout_o;
               last_off <= bus_addr_o[5:0];
               gapc <= 0;
               nload <= nload + 1;
               if (nload == 63) begin mst <= 4; mbusy <= busy_len; end
             end
          default: ;
        endcase
      end else if (mst == 3) begin
        gapc <= gapc + 1;
        if (gapc > GAP + 50) begin
          if (nload == 0) mst <= 0;
          else begin mst <= 4; mbusy <= busy_len; end
        end
      end
      if (mst == 4) begin
        if (mbusy > 1) mbusy <= mbusy - 1;
        else begin mbusy <= 0; mst <= 0; end
      end
    end
  end

  always_comb begin
    if (mst == 4)                      bus_din_i = {~mbuf[last_off][7], tog, mbuf[last_off][5:0]};
    else if (bus_addr_o[14:6] == msec) bus_din_i = mbuf[bus_addr_o[5:0]];
    else                               bus_din_i = 8'hFF;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic feed(input int n, input int seed, input int stall);
    for (int i = 0; i < n; i++) begin
      if (i == 20 && stall > 0) begin
        in_valid_i = 1'b0;
        repeat (stall) @(negedge clk);
      end
      in_valid_i = 1'b1;
      in_data_i  = pay(seed, i);
      while (!in_ready_o) @(negedge clk);
      @(negedge clk);
    end
    in_valid_i = 1'b0;
  endtask

  // res: 0 done, 1 timeout, 2 underrun, 3 nothing
  task automatic run_op(input int sec, input int mode, input int blen, input int seed,
                        input int stall, input int nbytes, output int res, output int mb);
    busy_len = blen;
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
    start_i = 1'b1; sector_i = 9'(sec); toggle_mode_i = mode[0];
    @(negedge clk); start_i = 1'b0;
    res = 3; mb = 0;
    fork
      feed(nbytes, seed, stall);
      begin
        repeat (20) @(negedge clk);
        start_i = 1'b1; sector_i = 9'(sec) ^ 9'h1;
        @(negedge clk);
        start_i = 1'b0; sector_i = 9'(sec);
      end
      begin
        for (int c = 0; c < 30000; c++) begin
          @(negedge clk);
          if (done_o)     begin res = 0; mb = mbusy; break; end
          if (timeout_o)  begin res = 1; mb = mbusy; break; end
          if (underrun_o) begin res = 2; mb = mbusy; break; end
        end
      end
    join
  endtask

  task automatic settle();
    for (int c = 0; c < 20000 && mst != 0; c++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int res, mb, mism, nw0;
    rst_n = 1'b0; start_i = 1'b0; toggle_mode_i = 1'b0; in_valid_i = 1'b0;
    sector_i = '0; in_data_i = '0; busy_len = 10; clr_stats = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_ce_n_o && bus_we_n_o && bus_oe_n_o && !bus_drv_o, "R1", {bus_ce_n_o, bus_we_n_o, bus_oe_n_o, bus_drv_o}, 14);
    chk(!in_ready_o && !busy_o && !done_o && !timeout_o && !underrun_o, "R1",
        {in_ready_o, busy_o, done_o, timeout_o, underrun_o}, 0);

    for (int v = 0; v < NV; v++) begin
      run_op(V_SEC[v], V_MODE[v], V_BUSY[v], V_SEED[v], V_STAL[v], 64, res, mb);
      if (V_EXP[v] == 0) begin
        chk(res == 0, V_MODE[v] ? "R8" : "R7", res, 0);
        chk(mb == 0, V_MODE[v] ? "R8" : "R7", mb, 0);
      end else begin
        chk(res == 1, "R9", res, 1);
        chk(mb != 0, "R9", mb, 1);
      end
      chk(ul_bad == 0, "R2", ul_bad, 0);
      chk(nwr == 67, "R5", nwr, 67);
      chk(ld_err == 0 && msec == 9'(V_SEC[v]), "R4", ld_err, 0);
      mism = 0;
      for (int i = 0; i < 64; i++) if (mbuf[i] != pay(V_SEED[v], i)) mism++;
      chk(mism == 0, "R4", mism, 0);
      chk(wl_min == WLOW && wl_max == WLOW, "R3", wl_max, WLOW);
      chk(ol_min == ACC && ol_max == ACC, "R11", ol_max, ACC);
      @(negedge clk);
      chk(!busy_o && !done_o && !timeout_o && !underrun_o && !in_ready_o, "R10",
          {busy_o, done_o, timeout_o, underrun_o}, 0);
      settle();
    end

    // R6: stream cut off after ten bytes
    run_op(9'h0C3, 0, 200, 8'h21, 0, 10, res, mb);
    chk(res == 2, "R6", res, 2);
    nw0 = nwr;
    chk(nw0 == 13, "R6", nw0, 13);
    repeat (100) @(negedge clk);
    chk(nwr == nw0 && !busy_o && bus_ce_n_o, "R6", nwr, nw0);
    settle();

    // R1 reset in the middle of a load
    busy_len = 20;
    @(negedge clk); start_i = 1'b1; sector_i = 9'h011; toggle_mode_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ce_n_o && bus_we_n_o && bus_oe_n_o && !busy_o && !in_ready_o, "R1",
        {bus_ce_n_o, bus_we_n_o, bus_oe_n_o, busy_o}, 14);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule